// File: doc/BRIEF.md
# Auto-Reload Interval Timer with Selectable Tick Divider

This block is a 16-bit up-counter on a byte-wide special-function-register bus. It runs in a single mode, automatic reload. Each time the count leaves its all-ones value, the counter takes a new start value from a pair of reload bytes. At the same moment a sticky overflow flag is raised. The flag drives the interrupt request and stays set until software writes it back to zero. Entering an interrupt does not clear it.

The counter does not advance on every clock. A divider turns the system clock into count ticks: one tick every 12 clocks, or every 24 clocks when the slow bit is set. Clearing the run bit holds both the count and the divider where they are. Setting it again carries on from the held values. Software programs the interval by writing the reload bytes. It can also preset or read the live count through two more byte registers.

Top module: `reload_timer16`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0x00 and `irq` is 0.
- R2: Register map on `sfr_addr`: 0xC8 control (bit 0 run, bit 7 slow; all other bits read 0), 0xC9 flags (bit 0 overflow; others read 0), 0xCA reload low byte, 0xCB reload high byte, 0xCC count low byte, 0xCD count high byte. A write takes effect at the clock edge where `sfr_wr` is 1. `sfr_rdata` is registered and shows the addressed register one clock after the address is presented.
- R3: With run=1 and slow=0, the count rises by one every 12 clocks. The first rise comes 12 clocks after the edge that sets the run bit.
- R4: With run=1 and slow=1, the count rises by one every 24 clocks.
- R5: With run=0, the count and the tick divider both hold their values. Setting run again resumes from the held divider phase, so two 6-clock run periods give one tick.
- R6: On a tick while the count is 0xFFFF, the count loads {reload high, reload low} and the overflow flag is set at that same edge.
- R7: A reload value of 0x0000 makes the count wrap from 0xFFFF to 0x0000, which gives the longest period of 65536 ticks.
- R8: The overflow flag stays set until software writes 0 to flag bit 0. If an overflow and such a write fall on the same edge, the flag ends up set.
- R9: A write to a count byte at the same edge as a tick wins: the written byte is stored and the increment of that tick is dropped.
- R10: `irq` is 1 exactly while the overflow flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Registered read data of the addressed register |
| irq | output | 1 | Interrupt request, follows the overflow flag |

## Verification
The counter is run for whole multiples of the 12- and 24-clock tick periods from a preset count. Each run is then stopped so the count can be read while frozen; this tells a correct divider ratio from a wrong one. Split run periods show whether stopping the timer also holds the divider phase or resets it. Counts preset just below 0xFFFF, with nonzero and zero reload values, separate a correct reload from a plain wrap, and show when the flag and `irq` rise. The flag-clear and count-byte writes are placed on the exact edge of a tick, which exposes the priority chosen for each collision.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SFR_W = 8;

  localparam logic [SFR_W-1:0] ADDR_CTRL   = 8'hC8;
  localparam logic [SFR_W-1:0] ADDR_FLAG   = 8'hC9;
  localparam logic [SFR_W-1:0] ADDR_RLD_LO = 8'hCA;
  localparam logic [SFR_W-1:0] ADDR_RLD_HI = 8'hCB;
  localparam logic [SFR_W-1:0] ADDR_CNT_LO = 8'hCC;
  localparam logic [SFR_W-1:0] ADDR_CNT_HI = 8'hCD;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_SLOW_BIT = 7;
  localparam int FLAG_OVF_BIT  = 0;
endpackage

// File: rtl/tick_div.sv
module tick_div #(
  parameter int BASE_DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic slow,
  output logic tick
);
  localparam int PRE_W = $clog2(2 * BASE_DIV);

  logic [PRE_W-1:0] phase;
  logic [PRE_W-1:0] limit;

  assign limit = slow ? PRE_W'(2 * BASE_DIV - 1) : PRE_W'(BASE_DIV - 1);
  assign tick  = run && (phase >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (run) begin
      if (phase >= limit) phase <= '0;
      else                phase <= phase + 1'b1;
    end
  end

  // R5: a stopped timer keeps its divider phase
  assert_phase_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(phase));

  // R3/R4: the phase never passes the slow limit
  assert_phase_range_R4: assert property (@(posedge clk) disable iff (rst)
    phase <= PRE_W'(2 * BASE_DIV - 1));
endmodule

// File: rtl/count16.sv
module count16 #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [BYTE_W-1:0]   wbyte,
  input  logic [2*BYTE_W-1:0] reload,
  output logic [2*BYTE_W-1:0] count,
  output logic                ovf
);
  localparam int CNT_W = 2 * BYTE_W;

  logic any_wr;
  assign any_wr = wr_lo | wr_hi;
  assign ovf    = tick && !any_wr && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (any_wr) begin
      if (wr_lo) count[BYTE_W-1:0]     <= wbyte;
      if (wr_hi) count[CNT_W-1:BYTE_W] <= wbyte;
    end else if (tick) begin
      if (count == {CNT_W{1'b1}}) count <= reload;
      else                        count <= count + 1'b1;
    end
  end

  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !any_wr && count == {CNT_W{1'b1}}) |=> count == $past(reload));

  assert_increment_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !any_wr && count != {CNT_W{1'b1}}) |=> count == $past(count) + 1'b1);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!tick && !any_wr) |=> $stable(count));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && tick) |=> count[BYTE_W-1:0] == $past(wbyte));
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
  import tmr_pkg::*;
#(
  parameter int BASE_DIV = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SFR_W-1:0] sfr_addr,
  input  logic             sfr_wr,
  input  logic [SFR_W-1:0] sfr_wdata,
  output logic [SFR_W-1:0] sfr_rdata,
  output logic             irq
);
  localparam int CNT_W = 2 * SFR_W;

  logic             run_q, slow_q, flag_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count;
  logic             tick, ovf;
  logic             wr_ctrl, wr_flag, wr_rlo, wr_rhi, wr_clo, wr_chi;

  assign wr_ctrl = sfr_wr && (sfr_addr == ADDR_CTRL);
  assign wr_flag = sfr_wr && (sfr_addr == ADDR_FLAG);
  assign wr_rlo  = sfr_wr && (sfr_addr == ADDR_RLD_LO);
  assign wr_rhi  = sfr_wr && (sfr_addr == ADDR_RLD_HI);
  assign wr_clo  = sfr_wr && (sfr_addr == ADDR_CNT_LO);
  assign wr_chi  = sfr_wr && (sfr_addr == ADDR_CNT_HI);

  tick_div #(.BASE_DIV(BASE_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (run_q),
    .slow (slow_q),
    .tick (tick)
  );

  count16 #(.BYTE_W(SFR_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .wr_lo  (wr_clo),
    .wr_hi  (wr_chi),
    .wbyte  (sfr_wdata),
    .reload (reload_q),
    .count  (count),
    .ovf    (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      slow_q   <= 1'b0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= sfr_wdata[CTRL_RUN_BIT];
        slow_q <= sfr_wdata[CTRL_SLOW_BIT];
      end
      if (wr_rlo) reload_q[SFR_W-1:0]     <= sfr_wdata;
      if (wr_rhi) reload_q[CNT_W-1:SFR_W] <= sfr_wdata;
    end
  end

  // overflow set takes priority over a software clear
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (ovf)     flag_q <= 1'b1;
    else if (wr_flag) flag_q <= sfr_wdata[FLAG_OVF_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sfr_rdata <= '0;
    end else begin
      sfr_rdata <= '0;
      unique case (sfr_addr)
        ADDR_CTRL: begin
          sfr_rdata[CTRL_RUN_BIT]  <= run_q;
          sfr_rdata[CTRL_SLOW_BIT] <= slow_q;
        end
        ADDR_FLAG:   sfr_rdata[FLAG_OVF_BIT] <= flag_q;
        ADDR_RLD_LO: sfr_rdata <= reload_q[SFR_W-1:0];
        ADDR_RLD_HI: sfr_rdata <= reload_q[CNT_W-1:SFR_W];
        ADDR_CNT_LO: sfr_rdata <= count[SFR_W-1:0];
        ADDR_CNT_HI: sfr_rdata <= count[CNT_W-1:SFR_W];
        default:     sfr_rdata <= '0;
      endcase
    end
  end

  assign irq = flag_q;

  assert_ovf_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    ovf |=> irq);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (irq && !wr_flag) |=> irq);

  assert_no_tick_stopped_R5: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> !tick);
endmodule

// File: tb/reload_timer16_test.sv
module reload_timer16_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sfr_addr = 8'h00;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  logic mon_go = 1'b0;
  bit   done   = 1'b0;

  int    exp_q[$];
  bit    kind_q[$];   // 0: read data, 1: irq
  string tag_q[$];

  always #4 clk = ~clk;

  reload_timer16 uut (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq(irq)
  );

  // monitor: pops one expected item per requested sample
  always @(posedge clk) begin
    if (mon_go) begin
      int  e;
      bit  k;
      string t;
      int  act;
      #1;
      e = exp_q.pop_front();
      k = kind_q.pop_front();
      t = tag_q.pop_front();
      act = k ? int'(irq) : int'(sfr_rdata);
      checks++;
      if (act !== e) begin
        fails++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", t, act, e);
      end
    end
  end

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input int e, input string t);
    exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
    sfr_addr = a; mon_go = 1'b1;
    @(negedge clk);
    mon_go = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_irq(input int e, input string t);
    exp_q.push_back(e); kind_q.push_back(1'b1); tag_q.push_back(t);
    mon_go = 1'b1;
    @(negedge clk);
    mon_go = 1'b0;
    @(negedge clk);
  endtask

  // run for exactly m active edges, then stop
  task automatic run_for(input int m, input bit slow);
    wr(8'hC8, {slow, 6'b0, 1'b1});
    repeat (m - 1) @(negedge clk);
    wr(8'hC8, {slow, 7'b0});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1 reset state
    expect_rd(8'hC8, 8'h00, "R1 ctrl");
    expect_rd(8'hC9, 8'h00, "R1 flag");
    expect_rd(8'hCA, 8'h00, "R1 reload lo");
    expect_rd(8'hCB, 8'h00, "R1 reload hi");
    expect_rd(8'hCC, 8'h00, "R1 count lo");
    expect_rd(8'hCD, 8'h00, "R1 count hi");
    expect_irq(0, "R1 irq");

    // R2 control readback, unused bits read 0
    wr(8'hC8, 8'h7E);
    expect_rd(8'hC8, 8'h00, "R2 ctrl unused bits");
    wr(8'hC8, 8'h80);
    expect_rd(8'hC8, 8'h80, "R2 ctrl slow bit");
    wr(8'hC8, 8'h00);

    // R2 count preset, R3 fast tick
    wr(8'hCC, 8'h34); wr(8'hCD, 8'h12);
    expect_rd(8'hCC, 8'h34, "R2 count lo");
    expect_rd(8'hCD, 8'h12, "R2 count hi");
    run_for(36, 1'b0);
    expect_rd(8'hCC, 8'h37, "R3 three ticks in 36 clocks");
    expect_rd(8'hCD, 8'h12, "R3 high byte");

    // R4 slow tick
    run_for(48, 1'b1);
    expect_rd(8'hCC, 8'h39, "R4 two ticks in 48 clocks");

    // R5 freeze
    repeat (30) @(negedge clk);
    expect_rd(8'hCC, 8'h39, "R5 stopped count holds");
    run_for(6, 1'b0);
    run_for(6, 1'b0);
    expect_rd(8'hCC, 8'h3A, "R5 divider phase resumes");

    // R6 reload and flag
    wr(8'hCA, 8'hF0); wr(8'hCB, 8'hFF);
    wr(8'hCC, 8'hFE); wr(8'hCD, 8'hFF);
    run_for(24, 1'b0);
    expect_rd(8'hCC, 8'hF0, "R6 reload lo");
    expect_rd(8'hCD, 8'hFF, "R6 reload hi");
    expect_rd(8'hC9, 8'h01, "R6 flag set");
    expect_irq(1, "R10 irq follows flag");

    // R8 sticky flag, software clear
    run_for(12, 1'b0);
    expect_rd(8'hCC, 8'hF1, "R8 counting after reload");
    expect_rd(8'hC9, 8'h01, "R8 flag sticky");
    wr(8'hC9, 8'h00);
    expect_rd(8'hC9, 8'h00, "R8 flag cleared");
    expect_irq(0, "R10 irq drops with flag");

    // R7 zero reload wraps to 0000
    wr(8'hCA, 8'h00); wr(8'hCB, 8'h00);
    wr(8'hCC, 8'hFF); wr(8'hCD, 8'hFF);
    run_for(12, 1'b0);
    expect_rd(8'hCC, 8'h00, "R7 wrap lo");
    expect_rd(8'hCD, 8'h00, "R7 wrap hi");
    expect_rd(8'hC9, 8'h01, "R7 flag on wrap");
    wr(8'hC9, 8'h00);

    // R8 overflow beats a clear on the same edge
    do_reset();
    wr(8'hCA, 8'h05);
    wr(8'hCC, 8'hFF); wr(8'hCD, 8'hFF);
    wr(8'hC8, 8'h01);
    repeat (11) @(negedge clk);
    wr(8'hC9, 8'h00);
    wr(8'hC8, 8'h00);
    expect_rd(8'hC9, 8'h01, "R8 set wins over clear");
    expect_rd(8'hCC, 8'h05, "R6 reload value 0x0005");

    // R9 count write beats the tick
    do_reset();
    wr(8'hCC, 8'hFF);
    wr(8'hC8, 8'h01);
    repeat (11) @(negedge clk);
    wr(8'hCC, 8'h50);
    wr(8'hC8, 8'h00);
    expect_rd(8'hCC, 8'h50, "R9 written lo kept");
    expect_rd(8'hCD, 8'h00, "R9 no carry");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule